// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller with Dual-Edge Interrupts

This block is a memory-mapped controller for one general-purpose I/O port of up to 32 lines. It sits on a simple 32-bit register bus. Each configuration vector (output data, direction, interrupt enable, interrupt mask, trigger type, polarity, debounce and dual-edge) is changed only by writing ones to a set address or a clear address. Because of this, several cores can change different lines at the same time without a read-modify-write. Bit n of every register belongs to line n.

The pins pass through a two-flop synchronizer and a filter register. The filter can require a change to stay stable for a parameterised number of cycles before it is accepted. Each line can raise an interrupt on a high level, a low level, a rising edge or a falling edge. A separate dual-edge enable overrides the trigger selection and fires on both edges. Edge events are latched until software acknowledges them with an end-of-interrupt write. Level events follow the filtered pin. The enabled and unmasked pending lines form the status word. Their OR, gated by a top-level enable bit, drives a single registered interrupt output.

Top module: `gpio_dedge_ctrl`

## Requirements
- R1: After reset every configuration vector and the top-level enable are zero. `gpio_o`, `gpio_oe_o` and `irq_o` are low, and the readable addresses return zero.
- R2: A write with a 1 in bit n to a set address sets bit n of that vector. A 1 in bit n to the matching clear address (set address + 4) clears it. Zero bits leave lines unchanged. The pairs are: data 0x000/0x004 (drives `gpio_o`), direction 0x010/0x014 (drives `gpio_oe_o`, 1 = output), enable 0x020/0x024, mask 0x030/0x034, trigger 0x040/0x044, polarity 0x050/0x054, debounce 0x060/0x064 and dual-edge 0x0B0/0x0B4.
- R3: A read strobe returns data on `rdata_o` one cycle later. With debounce off, address 0x080 returns the pins as they were three clock edges earlier (two synchronizer flops and one filter register).
- R4: With a line's debounce bit set, a change on that line is accepted only after the synchronized value has differed from the accepted value for DEB_CYCLES consecutive cycles. Shorter pulses are discarded.
- R5: With trigger bit 0 the line is level sensitive: polarity 1 means high and 0 means low. Its pending state follows the filtered pin and is not affected by end-of-interrupt writes.
- R6: With trigger bit 1 the line is edge sensitive: polarity 1 means rising and 0 means falling. An event is latched and stays pending until a 1 for that line is written to address 0x078.
- R7: With the dual-edge bit set, both rising and falling edges latch the line whatever its trigger and polarity bits hold. Address 0x0B8 reads the dual-edge vector back. Address 0x018 reads the direction vector back.
- R8: Address 0x070 returns the pending lines that are enabled and not masked. Edge events are latched only while the line is enabled. An event latched while the line is masked appears once the mask is cleared.
- R9: Bit 0 of address 0x0A0 is a readable top-level enable. `irq_o` is the registered OR of the status word gated by this bit.
- R10: Reads of the write-only set, clear and acknowledge addresses, and of unmapped addresses, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| gpio_i | input | NUM_LINES | Pin input values |
| gpio_o | output | NUM_LINES | Output data |
| gpio_oe_o | output | NUM_LINES | Output enable per line |
| irq_o | output | 1 | Combined interrupt |

## Verification
The interrupt path is driven with five trigger patterns on separate lines: level high, level low, rising, falling, and dual-edge. Each pattern is followed by an acknowledge write, which separates latched events from level-following ones.

Switching the dual-edge bit off while the pin rests low shows that the override gives way to the underlying level-low setting. Masked-then-unmasked and disabled-then-enabled events separate latching from reporting.

A 2-cycle and a 10-cycle pulse on a debounced line separate rejection from acceptance. Writing overlapping set and clear words shows that untouched lines keep their state.

// File: rtl/gpio_dedge_pkg.sv
package gpio_dedge_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int NPAIR  = 8;

  // set addresses of set/clear pairs; clear = set + 4
  localparam logic [ADDR_W-1:0] A_DOUT_SET = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIR_SET  = 8'h10;
  localparam logic [ADDR_W-1:0] A_IEN_SET  = 8'h20;
  localparam logic [ADDR_W-1:0] A_MSK_SET  = 8'h30;
  localparam logic [ADDR_W-1:0] A_TRIG_SET = 8'h40;
  localparam logic [ADDR_W-1:0] A_POL_SET  = 8'h50;
  localparam logic [ADDR_W-1:0] A_DEB_SET  = 8'h60;
  localparam logic [ADDR_W-1:0] A_BOTH_SET = 8'hB0;

  localparam logic [ADDR_W-1:0] A_DIR_RD   = 8'h18;
  localparam logic [ADDR_W-1:0] A_STAT_RD  = 8'h70;
  localparam logic [ADDR_W-1:0] A_ACK      = 8'h78;
  localparam logic [ADDR_W-1:0] A_PINS_RD  = 8'h80;
  localparam logic [ADDR_W-1:0] A_TOP_EN   = 8'hA0;
  localparam logic [ADDR_W-1:0] A_BOTH_RD  = 8'hB8;

  localparam int P_DOUT = 0;
  localparam int P_DIR  = 1;
  localparam int P_IEN  = 2;
  localparam int P_MSK  = 3;
  localparam int P_TRIG = 4;
  localparam int P_POL  = 5;
  localparam int P_DEB  = 6;
  localparam int P_BOTH = 7;

  localparam logic [ADDR_W-1:0] PAIR_SET [NPAIR] = '{
    A_DOUT_SET, A_DIR_SET, A_IEN_SET, A_MSK_SET,
    A_TRIG_SET, A_POL_SET, A_DEB_SET, A_BOTH_SET
  };
endpackage

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (set_i) q_q <= q_q | bits_i;
    else if (clr_i) q_q <= q_q & ~bits_i;
  end

  assign q_o = q_q;

  AST_SET_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(bits_i)) == $past(bits_i))); // R2
  AST_ZERO_BITS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> (((q_o ^ $past(q_o)) & ~$past(bits_i)) == '0)); // R2
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int NUM_LINES  = 32,
  parameter int DEB_CYCLES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [NUM_LINES-1:0] deb_en_i,
  output logic [NUM_LINES-1:0] filt_o
);
  localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [NUM_LINES-1:0] sync_v;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic s1_q, s2_q, f_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        f_q   <= 1'b0;
        cnt_q <= '0;
      end else begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
        if (s2_q == f_q) begin
          cnt_q <= '0;
        end else if (!deb_en_i[i] || cnt_q == CNT_LAST) begin
          f_q   <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign sync_v[i] = s2_q;
    assign filt_o[i] = f_q;
  end

  AST_NODEB_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_o ^ $past(sync_v)) & ~$past(deb_en_i)) == '0); // R3
  AST_CHANGE_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_o ^ $past(filt_o)) & (filt_o ^ $past(sync_v))) == '0); // R4
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] filt_i,
  input  logic [NUM_LINES-1:0] ien_i,
  input  logic [NUM_LINES-1:0] trig_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic [NUM_LINES-1:0] both_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] hit_v, lat_v;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic prev_q, lat_q, rise, fall, hit;

    assign rise = filt_i[i] & ~prev_q;
    assign fall = ~filt_i[i] & prev_q;
    // dual-edge wins over trigger/polarity
    assign hit  = both_i[i] ? (rise | fall)
                            : (trig_i[i] & (pol_i[i] ? rise : fall));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= filt_i[i];
        if (ien_i[i] && hit) lat_q <= 1'b1;
        else if (ack_i[i])   lat_q <= 1'b0;
      end
    end

    assign hit_v[i]  = hit;
    assign lat_v[i]  = lat_q;
    assign pend_o[i] = (both_i[i] | trig_i[i]) ? lat_q
                     : (pol_i[i] ? filt_i[i] : ~filt_i[i]);
  end

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_v & $past(ack_i & ~hit_v)) == '0)); // R6
  AST_LATCH_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_v & ~$past(lat_v) & ~$past(ien_i)) == '0)); // R8
endmodule

// File: rtl/gpio_dedge_regs.sv
module gpio_dedge_regs
  import gpio_dedge_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] cfg_o [NPAIR],
  output logic [NUM_LINES-1:0] ack_o,
  output logic                 top_en_o,
  output logic [BUS_W-1:0]     rdata_o
);
  logic [NUM_LINES-1:0] bits;
  logic                 top_en_q;
  logic [BUS_W-1:0]     rdata_q, rd_mux;

  assign bits = wdata_i[NUM_LINES-1:0];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] SET_A = PAIR_SET[p];
    localparam logic [ADDR_W-1:0] CLR_A = PAIR_SET[p] + ADDR_W'(4);
    gpio_setclr_bank #(.W(NUM_LINES)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr_en_i && addr_i == SET_A),
      .clr_i  (wr_en_i && addr_i == CLR_A),
      .bits_i (bits),
      .q_o    (cfg_o[p])
    );
  end

  assign ack_o = (wr_en_i && addr_i == A_ACK) ? bits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) top_en_q <= 1'b0;
    else if (wr_en_i && addr_i == A_TOP_EN) top_en_q <= wdata_i[0];
  end
  assign top_en_o = top_en_q;

  always_comb begin
    unique case (addr_i)
      A_DIR_RD:  rd_mux = BUS_W'(cfg_o[P_DIR]);
      A_BOTH_RD: rd_mux = BUS_W'(cfg_o[P_BOTH]);
      A_STAT_RD: rd_mux = BUS_W'(status_i);
      A_PINS_RD: rd_mux = BUS_W'(pins_i);
      A_TOP_EN:  rd_mux = BUS_W'(top_en_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_dedge_ctrl.sv
module gpio_dedge_ctrl
  import gpio_dedge_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int DEB_CYCLES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [7:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] gpio_i,
  output logic [NUM_LINES-1:0] gpio_o,
  output logic [NUM_LINES-1:0] gpio_oe_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] cfg [NPAIR];
  logic [NUM_LINES-1:0] ack, filt, pend, status;
  logic                 top_en, irq_q;

  gpio_dedge_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .pins_i   (filt),
    .status_i (status),
    .cfg_o    (cfg),
    .ack_o    (ack),
    .top_en_o (top_en),
    .rdata_o  (rdata_o)
  );

  gpio_pin_filter #(.NUM_LINES(NUM_LINES), .DEB_CYCLES(DEB_CYCLES)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (gpio_i),
    .deb_en_i (cfg[P_DEB]),
    .filt_o   (filt)
  );

  gpio_irq_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .filt_i (filt),
    .ien_i  (cfg[P_IEN]),
    .trig_i (cfg[P_TRIG]),
    .pol_i  (cfg[P_POL]),
    .both_i (cfg[P_BOTH]),
    .ack_i  (ack),
    .pend_o (pend)
  );

  assign status = pend & cfg[P_IEN] & ~cfg[P_MSK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= top_en & (|status);
  end

  assign irq_o     = irq_q;
  assign gpio_o    = cfg[P_DOUT];
  assign gpio_oe_o = cfg[P_DIR];

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_en |=> !irq_o); // R9
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(status != '0)); // R9
endmodule

// File: tb/gpio_dedge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_dedge_ctrl_test;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NL-1:0] pins = '0, gout, goe;
  logic          irq;
  int            n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_dedge_ctrl #(.NUM_LINES(NL), .DEB_CYCLES(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .gpio_i(pins),
    .gpio_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 gpio_o", gout, '0);
    chk("R1 gpio_oe_o", goe, '0);
    chk("R1 irq_o", {31'b0, irq}, '0);
    rdchk("R1 dir", 8'h18, '0);
    rdchk("R1 status", 8'h70, '0);
    rdchk("R1 dual", 8'hB8, '0);
    rdchk("R1 top_en", 8'hA0, '0);
  endtask

  task automatic t_setclr;
    wr(8'h00, 32'h0000_00F0);
    wr(8'h00, 32'h0000_0003);
    chk("R2 data set", gout, 32'h0000_00F3);
    wr(8'h04, 32'h0000_0030);
    chk("R2 data clear", gout, 32'h0000_00C3);
    wr(8'h10, 32'h0000_FF00);
    wr(8'h14, 32'h0000_0F00);
    chk("R2 dir", goe, 32'h0000_F000);
    rdchk("R7 dir readback", 8'h18, 32'h0000_F000);
    chk("R2 data untouched", gout, 32'h0000_00C3);
    rdchk("R10 set addr reads zero", 8'h00, '0);
    rdchk("R10 ack addr reads zero", 8'h78, '0);
    rdchk("R10 unmapped reads zero", 8'hFC, '0);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    pins = 32'hA5A5_1234;
    rd(8'h80, d);  // captured at 2nd edge after change: not yet visible
    chk("R3 ext latency", d, '0);
    rdchk("R3 ext value", 8'h80, 32'hA5A5_1234);
    pins = '0;
    cyc(4);
    rdchk("R3 ext back low", 8'h80, '0);
  endtask

  task automatic t_debounce;
    wr(8'h60, 32'h2);
    pins[1] = 1'b1; cyc(2); pins[1] = 1'b0;
    cyc(10);
    rdchk("R4 short pulse dropped", 8'h80, '0);
    pins[1] = 1'b1; cyc(10);
    rdchk("R4 long pulse accepted", 8'h80, 32'h2);
    pins[1] = 1'b0; cyc(10);
    wr(8'h64, 32'h2);
  endtask

  task automatic t_level;
    wr(8'h50, 32'h4);
    wr(8'h20, 32'h4);
    cyc(2);
    rdchk("R5 level high idle", 8'h70, '0);
    pins[2] = 1'b1; cyc(5);
    rdchk("R5 level high active", 8'h70, 32'h4);
    wr(8'h78, 32'h4); cyc(1);
    rdchk("R5 ack ignored", 8'h70, 32'h4);
    pins[2] = 1'b0; cyc(5);
    rdchk("R5 follows pin", 8'h70, '0);
    wr(8'h54, 32'h4); cyc(1);
    rdchk("R5 level low", 8'h70, 32'h4);
    wr(8'h24, 32'h4);
  endtask

  task automatic t_edge;
    wr(8'h40, 32'h8);
    wr(8'h50, 32'h8);
    wr(8'h20, 32'h8);
    pins[3] = 1'b1; cyc(5);
    rdchk("R6 rising latched", 8'h70, 32'h8);
    pins[3] = 1'b0; cyc(5);
    rdchk("R6 held after pin low", 8'h70, 32'h8);
    wr(8'h78, 32'h8); cyc(1);
    rdchk("R6 ack clears", 8'h70, '0);
    wr(8'h54, 32'h8);
    pins[3] = 1'b1; cyc(5);
    rdchk("R6 falling ignores rise", 8'h70, '0);
    pins[3] = 1'b0; cyc(5);
    rdchk("R6 falling latched", 8'h70, 32'h8);
    wr(8'h78, 32'h8);
    wr(8'h24, 32'h8);
  endtask

  task automatic t_dual;
    wr(8'hB0, 32'h10);
    wr(8'h20, 32'h10);
    cyc(2);
    rdchk("R7 dual overrides level low", 8'h70, '0);
    rdchk("R7 dual readback", 8'hB8, 32'h10);
    pins[4] = 1'b1; cyc(5);
    rdchk("R7 rise", 8'h70, 32'h10);
    wr(8'h78, 32'h10); cyc(1);
    rdchk("R7 ack", 8'h70, '0);
    pins[4] = 1'b0; cyc(5);
    rdchk("R7 fall", 8'h70, 32'h10);
    wr(8'h78, 32'h10);
    wr(8'hB4, 32'h10); cyc(1);
    rdchk("R7 dual cleared", 8'hB8, '0);
    rdchk("R7 falls back to level low", 8'h70, 32'h10);
    wr(8'h24, 32'h10);
  endtask

  task automatic t_mask;
    wr(8'h40, 32'h60);
    wr(8'h50, 32'h60);
    wr(8'h30, 32'h20);
    wr(8'h20, 32'h20);
    pins[5] = 1'b1; pins[6] = 1'b1; cyc(5);
    rdchk("R8 masked hidden", 8'h70, '0);
    wr(8'h34, 32'h20); cyc(1);
    rdchk("R8 unmask shows latched", 8'h70, 32'h20);
    wr(8'h20, 32'h40); cyc(1);
    rdchk("R8 disabled edge not latched", 8'h70, 32'h20);
    wr(8'h78, 32'h20);
    wr(8'h24, 32'h60);
    pins[5] = 1'b0; pins[6] = 1'b0; cyc(5);
  endtask

  task automatic t_irq;
    wr(8'h40, 32'h80);
    wr(8'h50, 32'h80);
    wr(8'h20, 32'h80);
    pins[7] = 1'b1; cyc(5);
    chk("R9 gated off", {31'b0, irq}, '0);
    wr(8'hA0, 32'h1); cyc(2);
    chk("R9 asserted", {31'b0, irq}, 32'h1);
    rdchk("R9 enable readback", 8'hA0, 32'h1);
    wr(8'h78, 32'h80); cyc(2);
    chk("R9 drops after ack", {31'b0, irq}, '0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset;
    t_setclr;
    t_ext;
    t_debounce;
    t_level;
    t_edge;
    t_dual;
    t_mask;
    t_irq;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule